// File: doc/BRIEF.md
# Reshapeable Dual-Port Memory with Optional FIFO Controller

This block holds 4,608 bits of storage behind one write port and one read port. Both ports are usable in the same clock cycle. A static 3-bit shape code picks one of six depth-by-width arrangements of that storage, from 128 deep by 36 wide down to 4096 deep by 1 wide. Addresses and data are right-justified: the block uses only the low address bits that the selected depth needs and only the low data bits that the selected width carries. Words are packed linearly, so word `a` of a shape `w` bits wide occupies storage bits `a*w` through `a*w+w-1`.

A static mode input turns the same storage into a synchronous first-in first-out queue. In that mode the addresses are ignored. Two pointers, each with one extra wrap bit, generate the slot numbers. A three-state controller tracks occupancy. The states are `F_EMPTY`, `F_PARTIAL` and `F_FULL`:

- `F_EMPTY` moves to `F_PARTIAL` on an accepted write.
- `F_PARTIAL` moves to `F_FULL` when an accepted write brings the count up to the depth.
- `F_PARTIAL` moves to `F_EMPTY` when an accepted read takes out the last item.
- `F_FULL` moves back to `F_PARTIAL` on an accepted read.
- A read and a write accepted together leave the state unchanged.

In plain RAM mode, a read and a write to the same address in the same cycle is not supported. The block flags it instead of defining the data.

Top module: `shapeable_ram_fifo`

## Requirements
- R1: Shape codes are 0:128x36, 1:256x18, 2:512x9, 3:1024x4, 4:2048x2 and 5:4096x1. Only address bits below log2(depth) are used, and only data bits below the width are stored. `rd_data` bits at or above the width read as 0. The shape code and the mode change only while reset is held.
- R2: In RAM mode, `rd_data` shows the word at `rd_addr` one clock after `rd_en` is sampled high. `rd_data` keeps its value in any cycle without an accepted read.
- R3: In RAM mode, a write and a read to different addresses in the same cycle both take effect. The read returns the contents held before that write.
- R4: In RAM mode, `wr_en` and `rd_en` together on equal (masked) addresses set `collision` high for the one cycle in which `rd_data` updates; otherwise `collision` is 0. `collision` is always 0 in FIFO mode.
- R5: Word `a` of a shape of width `w` occupies storage bits `a*w` to `a*w+w-1`. A 36-bit word written at address 0 in shape 0 reads back as single bits at addresses 0..35 in shape 5 (bit k at address k).
- R6: While reset is held, and after it is released, `rd_data`, `collision`, `full`, `wr_err` and `rd_err` are 0 and `empty` is 1.
- R7: In FIFO mode (`fifo_mode`=1), items come out in write order, the depth equals the selected shape's depth, and `wr_addr`/`rd_addr` have no effect.
- R8: `full` and `empty` update at the clock edge that accepts the operation. `full` rises after exactly depth writes without reads. The two flags are never both high.
- R9: A FIFO write while `full` is ignored. `wr_err` is high for exactly the following cycle.
- R10: A FIFO read while `empty` is ignored and leaves `rd_data` unchanged. `rd_err` is high for exactly the following cycle.
- R11: A FIFO read and write in the same cycle are both accepted when the queue is neither empty nor full, and the count stays the same. When the queue is full, the read is accepted and the write is rejected with `wr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shape_sel | input | 3 | Shape code 0..5, static outside reset |
| fifo_mode | input | 1 | 1 selects FIFO operation, static outside reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write address, right-justified (RAM mode) |
| wr_data | input | 36 | Write data, right-justified |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address, right-justified (RAM mode) |
| rd_data | output | 36 | Registered read data |
| collision | output | 1 | Same-address read/write flag, aligned with rd_data |
| full | output | 1 | FIFO full |
| empty | output | 1 | FIFO empty |
| wr_err | output | 1 | Rejected FIFO write pulse |
| rd_err | output | 1 | Rejected FIFO read pulse |

## Verification
- **Wrong occupancy state:** the controller state is visible directly on `full` and `empty` at the next sampling point. A missed transition also shows as a lost or repeated item within one depth's worth of reads.
- **Pointer faults:** a pointer that wraps at the wrong depth surfaces as out-of-order data, or a `full` flag that rises early or late, when the queue is filled to exactly its depth.
- **Packing faults:** a wrong bit-packing base or width mask corrupts words one cycle after a read. Reading the same storage back under a second shape exposes packing errors that a single shape would hide.

// File: rtl/shp_pkg.sv
package shp_pkg;
    localparam int TOTAL_BITS = 4608;
    localparam int MAX_W      = 36;
    localparam int AW         = 12;
    localparam int BASE_DEPTH = 128;
    localparam int NUM_SHAPES = 6;

    typedef enum logic [1:0] {
        F_EMPTY   = 2'd0,
        F_PARTIAL = 2'd1,
        F_FULL    = 2'd2
    } fifo_state_t;
endpackage

// File: rtl/shp_shape_decode.sv
module shp_shape_decode #(
    parameter int TOTAL_BITS = shp_pkg::TOTAL_BITS,
    parameter int MAX_W      = shp_pkg::MAX_W,
    parameter int AW         = shp_pkg::AW,
    parameter int BASE_DEPTH = shp_pkg::BASE_DEPTH,
    parameter int NUM_SHAPES = shp_pkg::NUM_SHAPES,
    localparam int WID_W     = $clog2(MAX_W + 1)
) (
    input  logic [2:0]       code,
    output logic [WID_W-1:0] width,
    output logic [AW-1:0]    amask
);
    localparam int BASE_AB = $clog2(BASE_DEPTH);

    // Each shape doubles the depth; width is the storage divided by depth.
    always_comb begin
        width = WID_W'(TOTAL_BITS / (BASE_DEPTH << (NUM_SHAPES - 1)));
        amask = AW'((1 << (BASE_AB + NUM_SHAPES - 1)) - 1);
        for (int k = 0; k < NUM_SHAPES; k++) begin
            if (int'(code) == k) begin
                width = WID_W'(TOTAL_BITS / (BASE_DEPTH << k));
                amask = AW'((1 << (BASE_AB + k)) - 1);
            end
        end
    end
endmodule

// File: rtl/shp_fifo_ctrl.sv
module shp_fifo_ctrl #(
    parameter int AW = shp_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic [AW-1:0] amask,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty,
    output logic          wr_err,
    output logic          rd_err
);
    import shp_pkg::*;

    localparam int PW = AW + 1;

    logic [PW-1:0] wp, rp, wp_n, rp_n, pmask, depth;
    fifo_state_t   st, st_n;

    assign pmask = {amask, 1'b1};
    assign depth = {1'b0, amask} + PW'(1);
    assign waddr = wp[AW-1:0] & amask;
    assign raddr = rp[AW-1:0] & amask;

    // Outputs and acceptance per state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        unique case (st)
            F_EMPTY: begin
                empty = 1'b1;
                wr_ok = fifo_on && wr_en;
            end
            F_PARTIAL: begin
                wr_ok = fifo_on && wr_en;
                rd_ok = fifo_on && rd_en;
            end
            F_FULL: begin
                full  = 1'b1;
                rd_ok = fifo_on && rd_en;
            end
            default: ;
        endcase
    end

    // Next pointers and next occupancy state
    always_comb begin
        wp_n = wr_ok ? ((wp + PW'(1)) & pmask) : wp;
        rp_n = rd_ok ? ((rp + PW'(1)) & pmask) : rp;
        if (wp_n == rp_n)
            st_n = F_EMPTY;
        else if ((wp_n ^ rp_n) == depth)
            st_n = F_FULL;
        else
            st_n = F_PARTIAL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= F_EMPTY;
            wp     <= '0;
            rp     <= '0;
            wr_err <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            st     <= st_n;
            wp     <= wp_n;
            rp     <= rp_n;
            wr_err <= fifo_on && wr_en && (st == F_FULL);
            rd_err <= fifo_on && rd_en && (st == F_EMPTY);
        end
    end

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !(fifo_on && rd_en) |=> full);
    p_empty_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !(fifo_on && wr_en) |=> empty);
    p_wr_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(full));
    p_rd_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(empty));
endmodule

// File: rtl/shp_bit_store.sv
module shp_bit_store #(
    parameter int TOTAL_BITS = shp_pkg::TOTAL_BITS,
    parameter int MAX_W      = shp_pkg::MAX_W,
    parameter int AW         = shp_pkg::AW,
    localparam int WID_W     = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WID_W-1:0] width,
    input  logic             wr_go,
    input  logic [AW-1:0]    waddr,
    input  logic [MAX_W-1:0] wdata,
    input  logic             rd_go,
    input  logic [AW-1:0]    raddr,
    output logic [MAX_W-1:0] rd_data
);
    localparam int IW = $clog2(TOTAL_BITS);

    logic [TOTAL_BITS-1:0] mem;
    logic [IW-1:0]         wbase, rbase;

    assign wbase = IW'(waddr) * IW'(width);
    assign rbase = IW'(raddr) * IW'(width);

    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int i = 0; i < MAX_W; i++) begin
                if (i < int'(width))
                    mem[wbase + IW'(i)] <= wdata[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_go) begin
            for (int i = 0; i < MAX_W; i++)
                rd_data[i] <= (i < int'(width)) ? mem[rbase + IW'(i)] : 1'b0;
        end
    end

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/shapeable_ram_fifo.sv
module shapeable_ram_fifo #(
    parameter int TOTAL_BITS = shp_pkg::TOTAL_BITS,
    parameter int MAX_W      = shp_pkg::MAX_W,
    parameter int AW         = shp_pkg::AW,
    parameter int BASE_DEPTH = shp_pkg::BASE_DEPTH,
    parameter int NUM_SHAPES = shp_pkg::NUM_SHAPES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       shape_sel,
    input  logic             fifo_mode,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [MAX_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [MAX_W-1:0] rd_data,
    output logic             collision,
    output logic             full,
    output logic             empty,
    output logic             wr_err,
    output logic             rd_err
);
    localparam int WID_W = $clog2(MAX_W + 1);

    logic [WID_W-1:0] width;
    logic [AW-1:0]    amask, wa_m, ra_m, f_waddr, f_raddr, st_waddr, st_raddr;
    logic             f_wr_ok, f_rd_ok, st_wr, st_rd;

    shp_shape_decode #(
        .TOTAL_BITS (TOTAL_BITS),
        .MAX_W      (MAX_W),
        .AW         (AW),
        .BASE_DEPTH (BASE_DEPTH),
        .NUM_SHAPES (NUM_SHAPES)
    ) u_dec (
        .code  (shape_sel),
        .width (width),
        .amask (amask)
    );

    shp_fifo_ctrl #(.AW(AW)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_on (fifo_mode),
        .amask   (amask),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_ok   (f_wr_ok),
        .rd_ok   (f_rd_ok),
        .waddr   (f_waddr),
        .raddr   (f_raddr),
        .full    (full),
        .empty   (empty),
        .wr_err  (wr_err),
        .rd_err  (rd_err)
    );

    assign wa_m     = wr_addr & amask;
    assign ra_m     = rd_addr & amask;
    assign st_wr    = fifo_mode ? f_wr_ok : wr_en;
    assign st_rd    = fifo_mode ? f_rd_ok : rd_en;
    assign st_waddr = fifo_mode ? f_waddr : wa_m;
    assign st_raddr = fifo_mode ? f_raddr : ra_m;

    shp_bit_store #(
        .TOTAL_BITS (TOTAL_BITS),
        .MAX_W      (MAX_W),
        .AW         (AW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .width   (width),
        .wr_go   (st_wr),
        .waddr   (st_waddr),
        .wdata   (wr_data),
        .rd_go   (st_rd),
        .raddr   (st_raddr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            collision <= 1'b0;
        else
            collision <= !fifo_mode && wr_en && rd_en && (wa_m == ra_m);
    end

    p_shape_static_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(shape_sel) && $stable(fifo_mode));
    p_coll_fifo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |-> !collision);
endmodule

// File: tb/shapeable_ram_fifo_test.sv
`timescale 1ns/1ps
module shapeable_ram_fifo_test;
    typedef struct {
        logic [35:0] v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  shape_sel;
    logic        fifo_mode, wr_en, rd_en;
    logic [11:0] wr_addr, rd_addr;
    logic [35:0] wr_data, rd_data;
    logic        collision, full, empty, wr_err, rd_err;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   drv_rd = 1'b0;
    bit   arm    = 1'b0;
    exp_t sb[$];
    logic [35:0] fm[$];
    logic [35:0] fmask;
    logic [35:0] last_v;
    exp_t        got;

    always #10 clk = ~clk;

    shapeable_ram_fifo uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shape_sel (shape_sel),
        .fifo_mode (fifo_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .collision (collision),
        .full      (full),
        .empty     (empty),
        .wr_err    (wr_err),
        .rd_err    (rd_err)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard one cycle after each expected read
    always @(posedge clk) arm <= drv_rd;
    always @(negedge clk) begin
        if (arm) begin
            if (sb.size() == 0) begin
                check("scoreboard underflow", 36'd1, 36'd0);
            end else begin
                got = sb.pop_front();
                check(got.tag, rd_data, got.v);
            end
        end
    end

    task automatic op(input bit we, input logic [11:0] wa, input logic [35:0] wd,
                      input bit re, input logic [11:0] ra,
                      input bit exp_rd, input logic [35:0] ev, input string tag);
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        rd_en   = re;
        rd_addr = ra;
        drv_rd  = exp_rd;
        if (exp_rd) sb.push_back('{ev, tag});
        @(negedge clk);
    endtask

    task automatic idle();
        op(1'b0, 12'd0, 36'd0, 1'b0, 12'd0, 1'b0, 36'd0, "");
    endtask

    task automatic ram_wr(input logic [11:0] a, input logic [35:0] d);
        op(1'b1, a, d, 1'b0, 12'd0, 1'b0, 36'd0, "");
    endtask

    task automatic ram_rd(input logic [11:0] a, input logic [35:0] ev, input string tag);
        op(1'b0, 12'd0, 36'd0, 1'b1, a, 1'b1, ev, tag);
    endtask

    task automatic f_wr(input logic [35:0] v);
        op(1'b1, 12'($urandom), v, 1'b0, 12'($urandom), 1'b0, 36'd0, "");
        fm.push_back(v & fmask);
    endtask

    task automatic f_rd(input string tag);
        logic [35:0] ev;
        ev = fm.pop_front();
        last_v = ev;
        op(1'b0, 12'($urandom), 36'd0, 1'b1, 12'($urandom), 1'b1, ev, tag);
    endtask

    task automatic do_reset(input logic [2:0] shp, input logic fm_on);
        rst_n     = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        wr_addr   = '0;
        rd_addr   = '0;
        wr_data   = '0;
        drv_rd    = 1'b0;
        shape_sel = shp;
        fifo_mode = fm_on;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [35:0] x;
        logic [35:0] ev;
        fmask = 36'hF_FFFF_FFFF;

        // R6: reset state
        do_reset(3'd0, 1'b0);
        check("R6 rd_data", rd_data, 36'd0);
        check("R6 empty", {35'd0, empty}, 36'd1);
        check("R6 full/coll/errs", {32'd0, full, collision, wr_err, rd_err}, 36'd0);

        // R2 / R1: plain reads in shape 0, address masking
        ram_wr(12'd5,   36'h9_8765_4321);
        ram_wr(12'd127, 36'hF_0F0F_0F0F);
        ram_wr(12'd131, 36'h1_2345_6789);      // masks to address 3
        ram_rd(12'd5,   36'h9_8765_4321, "R2 read addr5");
        ram_rd(12'd127, 36'hF_0F0F_0F0F, "R2 read addr127");
        ram_rd(12'd3,   36'h1_2345_6789, "R1 address mask");
        idle();
        check("R2 hold without read", rd_data, 36'h1_2345_6789);

        // R3: read and write to different addresses together
        op(1'b1, 12'd10, 36'hC_AFE0_BEEF, 1'b1, 12'd5, 1'b1, 36'h9_8765_4321, "R3 concurrent read");
        ram_rd(12'd10, 36'hC_AFE0_BEEF, "R3 concurrent write landed");

        // R4: same-address collision
        ram_wr(12'd20, 36'h0_AAAA_5555);
        op(1'b1, 12'd20, 36'h7_1111_2222, 1'b1, 12'd20, 1'b0, 36'd0, "");
        check("R4 collision raised", {35'd0, collision}, 36'd1);
        idle();
        check("R4 collision one cycle", {35'd0, collision}, 36'd0);
        ram_rd(12'd20, 36'h7_1111_2222, "R4 write after collision");

        // R5: linear packing seen through shape 5
        x = 36'hA_5C3F_0961;
        ram_wr(12'd0, x);
        idle();
        do_reset(3'd5, 1'b0);
        for (int k = 0; k < 36; k++)
            ram_rd(12'(k), {35'd0, x[k]}, "R5 bit slice");
        idle();

        // R1: shape 1 width and depth masking
        do_reset(3'd1, 1'b0);
        ram_wr(12'd255, 36'hF_FFFF_FFFF);
        ram_wr(12'd257, 36'h0_0001_2345);      // masks to address 1
        ram_rd(12'd255, 36'h0_0003_FFFF, "R1 width mask");
        ram_rd(12'd1,   36'h0_0001_2345, "R1 depth mask");
        idle();

        // FIFO in shape 2 (512 x 9)
        do_reset(3'd2, 1'b1);
        fmask = 36'h0_0000_01FF;
        check("R6 fifo empty", {35'd0, empty}, 36'd1);
        f_wr(36'hABC00_0000 | 36'd1);
        check("R8 empty falls", {35'd0, empty}, 36'd0);
        f_wr(36'hABC00_0000 | 36'd74);
        f_wr(36'hABC00_0000 | 36'd111);

        // R11: simultaneous read and write while partial
        ev = fm.pop_front();
        fm.push_back(36'h0_0000_0155 & fmask);
        op(1'b1, 12'd7, 36'h0_0000_0155, 1'b1, 12'd9, 1'b1, ev, "R11 partial read");
        check("R11 flags", {34'd0, full, empty}, 36'd0);

        while (fm.size() < 512) begin
            f_wr(36'hABC00_0000 | 36'(fm.size() * 37));
            if (fm.size() == 511) check("R8 not full at depth-1", {35'd0, full}, 36'd0);
        end
        check("R8 full at depth", {35'd0, full}, 36'd1);

        // R9: write while full
        op(1'b1, 12'd3, 36'h0_0000_01FF, 1'b0, 12'd0, 1'b0, 36'd0, "");
        check("R9 wr_err", {35'd0, wr_err}, 36'd1);
        check("R9 still full", {35'd0, full}, 36'd1);
        idle();
        check("R9 wr_err one cycle", {35'd0, wr_err}, 36'd0);

        // R11: read and write together while full
        ev = fm.pop_front();
        op(1'b1, 12'd0, 36'h0_0000_0055, 1'b1, 12'd0, 1'b1, ev, "R11 full read");
        check("R11 write rejected", {35'd0, wr_err}, 36'd1);
        check("R11 full drops", {35'd0, full}, 36'd0);

        // R7: drain in order
        while (fm.size() > 0) f_rd("R7 order");
        check("R8 empty after drain", {35'd0, empty}, 36'd1);

        // R10: read while empty
        op(1'b0, 12'd0, 36'd0, 1'b1, 12'd0, 1'b0, 36'd0, "");
        check("R10 rd_err", {35'd0, rd_err}, 36'd1);
        check("R10 rd_data unchanged", rd_data, last_v);
        idle();
        check("R10 rd_err one cycle", {35'd0, rd_err}, 36'd0);
        idle();

        summary();
        $finish;
    end
endmodule